// File: doc/BRIEF.md
# Pulse Interval Capture Timer

This block is a single timer channel that measures the time between successive qualifying transitions on an asynchronous input pin. A free-running up-counter advances once per count-clock enable. The count clock is picked from a small set of prescaled enables. When a qualifying transition arrives, the block acts in one cycle. It stores the running count in a capture register and restarts the counter from zero. One cycle later it raises a single-cycle interrupt. The next measurement therefore begins at once, with no gap.

Software controls the channel with two strobes. A start strobe turns an idle channel on with a cleared counter. A start strobe on a running channel forces an immediate capture, exactly as if an edge had arrived. A stop strobe turns the channel off and freezes the counter. Each capture also carries an overflow flag. The flag tells whether the counter wrapped during the period just measured, so the interval in count clocks is 2^CNT_W × flag + capture + 1. That sum is exact only while the counter wraps at most once.

Top module: `pulse_interval_timer`

## Requirements
- R1: After reset, `cap_data` is 0, `ovf_flag` is 0, `irq` is 0 and `chan_en` is 0.
- R2: A `start_wr` pulse while `chan_en` is 0 sets `chan_en` and clears the counter. The counter then rises by one at every later selected count-clock enable. The first capture therefore reports the number of enables between the start and the capture, minus one.
- R3: `edge_sel` sets which input transitions count as valid: 0 means rising only, 1 means falling only, 2 and 3 mean both. A transition that is not selected neither captures nor clears the counter.
- R4: On a capture, `cap_data` takes the running count and the counter returns to 0 in the same cycle. The next capture therefore reports the enables since the previous capture, minus one.
- R5: `irq` is high for exactly the cycle after each capture. In that same cycle `cap_data` and `ovf_flag` show the new values.
- R6: At each capture, `ovf_flag` becomes 1 if the counter wrapped from all-ones to zero since the previous capture or start, and 0 otherwise. Between captures `ovf_flag` does not change.
- R7: Two or more wraps within one period still give only `ovf_flag` = 1. `cap_data` then holds the interval modulo 2^CNT_W.
- R8: A `start_wr` pulse while `chan_en` is 1 performs a capture in that cycle, with the same effects as a valid edge.
- R9: A `stop_wr` pulse clears `chan_en`. While `chan_en` is 0, the counter holds and input transitions cause no capture and no `irq`. A `start_wr` pulse given while `chan_en` is 0 causes no capture.
- R10: The counter advances only on `tick_en[clk_sel]`. With a source that is high every fourth clock, edges spaced 4k clocks apart capture k−1.
- R11: The pin passes through a two-stage synchroniser and is sampled on count-clock enables. With an enable on every clock, the capture takes place at the third rising clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | N_SRC | Prescaled count-clock enables |
| clk_sel | input | SEL_W | Selects the count-clock enable |
| edge_sel | input | 2 | Valid-edge choice (0 rise, 1 fall, 2/3 both) |
| pulse_in | input | 1 | Asynchronous measured input |
| start_wr | input | 1 | Start strobe / software capture when running |
| stop_wr | input | 1 | Stop strobe |
| chan_en | output | 1 | Channel running |
| cap_data | output | CNT_W | Last captured count |
| ovf_flag | output | 1 | Wrap status of the last captured period |
| irq | output | 1 | One-cycle capture interrupt |

## Verification
The hardest state to reach from the ports is a period in which the counter wraps two or more times. Only then does the single-bit flag lose information, which R7 covers. The bench builds the timer with a 10-bit counter so that both a single wrap and a double wrap fit in a few thousand clocks. It then follows with a short period to show the flag clearing. A second situation is hard to reach: measurement on a prescaled count clock. There the sampling phase makes the first interval uncertain. The bench therefore checks only the intervals after the first one, which are set by the edge spacing.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    EDG_RISE = 2'd0,
    EDG_FALL = 2'd1,
    EDG_BOTH = 2'd2,
    EDG_ANY  = 2'd3
  } edge_mode_e;

  // Decide whether a sampled transition qualifies under the chosen mode.
  function automatic logic edge_match(input logic [1:0] mode, input logic prev, input logic cur);
    logic rise;
    logic fall;
    logic res;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (mode)
      EDG_RISE: res = rise;
      EDG_FALL: res = fall;
      default:  res = rise | fall;
    endcase
    return res;
  endfunction

  // Interval in count clocks implied by a capture and its wrap flag.
  function automatic longint unsigned span_of(input int cnt_w, input logic ovf, input longint unsigned cap);
    return (ovf ? (longint'(1) << cnt_w) : 0) + cap + 1;
  endfunction
endpackage

// File: rtl/pit_sync.sv
module pit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pit_tick_sel.sv
module pit_tick_sel #(
  parameter int N_SRC = 4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = src[g] && (sel == SEL_W'(g));
  end

  assign tick = |hit;
endmodule

// File: rtl/pit_edge.sv
module pit_edge
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] mode,
  input  logic       din,
  output logic       hit
);
  logic prev;

  // The synchronised pin is sampled only at count-clock enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev <= 1'b0;
    else if (tick) prev <= din;
  end

  assign hit = tick && edge_match(mode, prev, din);
endmodule

// File: rtl/pit_core.sv
module pit_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             edge_hit,
  input  logic             start_wr,
  input  logic             stop_wr,
  output logic             chan_en,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_data,
  output logic             ovf_flag,
  output logic             ovf_seen,
  output logic             irq,
  output logic             cap_evt,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic arm_evt;

  assign arm_evt  = !chan_en && start_wr;
  assign cap_evt  = chan_en && (edge_hit || start_wr);
  assign wrap_evt = chan_en && tick && !cap_evt && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chan_en <= 1'b0;
    else if (stop_wr)  chan_en <= 1'b0;
    else if (start_wr) chan_en <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (arm_evt)          cnt <= '0;
    else if (cap_evt)          cnt <= '0;
    else if (chan_en && tick)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ovf_seen <= 1'b0;
    else if (arm_evt || cap_evt) ovf_seen <= 1'b0;
    else if (wrap_evt)          ovf_seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_data <= '0;
      ovf_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= cap_evt;
      if (cap_evt) begin
        cap_data <= cnt;
        ovf_flag <= ovf_seen;
      end
    end
  end
endmodule

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer #(
  parameter int CNT_W  = 16,
  parameter int N_SRC  = 4,
  parameter int SYNC_N = 2,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] tick_en,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [1:0]       edge_sel,
  input  logic             pulse_in,
  input  logic             start_wr,
  input  logic             stop_wr,
  output logic             chan_en,
  output logic [CNT_W-1:0] cap_data,
  output logic             ovf_flag,
  output logic             irq
);
  // Named internal events, brought out for the bound checker.
  logic             tick_w;
  logic             pin_s;
  logic             edge_w;
  logic             cap_w;
  logic             wrap_w;
  logic             ovf_seen_w;
  logic [CNT_W-1:0] cnt_w;

  pit_tick_sel #(.N_SRC(N_SRC)) u_tick (
    .src (tick_en),
    .sel (clk_sel),
    .tick(tick_w)
  );

  pit_sync #(.STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pulse_in),
    .q    (pin_s)
  );

  pit_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_w),
    .mode (edge_sel),
    .din  (pin_s),
    .hit  (edge_w)
  );

  pit_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .edge_hit(edge_w),
    .start_wr(start_wr),
    .stop_wr (stop_wr),
    .chan_en (chan_en),
    .cnt     (cnt_w),
    .cap_data(cap_data),
    .ovf_flag(ovf_flag),
    .ovf_seen(ovf_seen_w),
    .irq     (irq),
    .cap_evt (cap_w),
    .wrap_evt(wrap_w)
  );
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en,
  input logic             start_wr,
  input logic             stop_wr,
  input logic             tick,
  input logic             cap_evt,
  input logic             wrap_evt,
  input logic             ovf_seen,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cap_data,
  input logic             ovf_flag,
  input logic             irq
);
  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && tick && !cap_evt) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && start_wr && !stop_wr) |=> (chan_en && cnt == '0));

  p_clear_on_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cnt == '0));

  p_capture_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_data == $past(cnt)));

  p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> irq);

  p_irq_only_after_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> !irq);

  p_ovf_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(ovf_flag));

  p_ovf_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (ovf_flag == $past(ovf_seen)));

  p_wrap_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_seen);

  p_off_no_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !cap_evt);

  p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !start_wr) |=> $stable(cnt));

  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> !chan_en);
endmodule

bind pulse_interval_timer pit_checker #(.CNT_W(CNT_W)) u_pit_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .chan_en (chan_en),
  .start_wr(start_wr),
  .stop_wr (stop_wr),
  .tick    (tick_w),
  .cap_evt (cap_w),
  .wrap_evt(wrap_w),
  .ovf_seen(ovf_seen_w),
  .cnt     (cnt_w),
  .cap_data(cap_data),
  .ovf_flag(ovf_flag),
  .irq     (irq)
);

// File: tb/pulse_interval_timer_tb_top.sv
`timescale 1ns/1ps
module pulse_interval_timer_tb_top;
  localparam int W = 10;
  localparam int MOD = 1 << W;

  typedef struct {
    int    cap;
    bit    ovf;
    bit    chk_ovf;
    bit    chk_cap;
    int    at;
    string tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   tick_en;
  logic [1:0]   clk_sel = 2'd0;
  logic [1:0]   edge_sel = 2'd2;
  logic         pulse_in = 1'b0;
  logic         start_wr = 1'b0;
  logic         stop_wr = 1'b0;
  logic         chan_en;
  logic [W-1:0] cap_data;
  logic         ovf_flag;
  logic         irq;

  int   cyc = 0;
  logic [2:0] div = '0;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   last_cap = 0;
  int   ratio = 1;
  bit   first_after_start = 0;
  bit   model_on = 0;
  bit   done = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) div <= div + 1'b1;
  assign tick_en = {div == 3'd0, div[1:0] == 2'd0, div[0] == 1'b0, 1'b1};

  pulse_interval_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clk_sel(clk_sel),
    .edge_sel(edge_sel), .pulse_in(pulse_in), .start_wr(start_wr),
    .stop_wr(stop_wr), .chan_en(chan_en), .cap_data(cap_data),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // Expected capture at posedge index c, derived from the counting rules.
  task automatic push_at(input int c, input string tag);
    exp_t e;
    int   span;
    span = c - last_cap - 1;
    e.cap = span % MOD;
    e.ovf = (span >= MOD);
    e.chk_ovf = 1;
    e.chk_cap = 1;
    e.at = c;
    e.tag = tag;
    last_cap = c;
    sb.push_back(e);
  endtask

  task automatic push_raw(input int capv, input bit chk, input string tag);
    exp_t e;
    e.cap = capv; e.ovf = 0; e.chk_ovf = chk; e.chk_cap = chk; e.at = -1; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic do_start(input string tag);
    @(negedge clk);
    start_wr = 1'b1;
    last_cap = cyc + 1;
    model_on = 1;
    first_after_start = 1;
    @(negedge clk);
    start_wr = 1'b0;
    check(chan_en === 1'b1, tag, int'(chan_en), 1);
  endtask

  task automatic do_stop(input string tag);
    @(negedge clk);
    stop_wr = 1'b1;
    model_on = 0;
    @(negedge clk);
    stop_wr = 1'b0;
    check(chan_en === 1'b0, tag, int'(chan_en), 0);
  endtask

  // Toggle the pin n clocks from now; predict a capture if the edge qualifies.
  task automatic toggle_after(input int n, input string tag);
    bit nv;
    bit ok_edge;
    repeat (n) @(negedge clk);
    nv = ~pulse_in;
    ok_edge = (edge_sel[1] == 1'b1) || (edge_sel == 2'd0 && nv) || (edge_sel == 2'd1 && !nv);
    pulse_in = nv;
    if (model_on && ok_edge) begin
      if (ratio == 1) push_at(cyc + 3, tag);
      else begin
        push_raw(n / ratio - 1, !first_after_start, tag);
      end
      first_after_start = 0;
    end
  endtask

  task automatic sw_capture_after(input int n, input string tag);
    repeat (n) @(negedge clk);
    start_wr = 1'b1;
    push_at(cyc + 1, tag);
    @(negedge clk);
    start_wr = 1'b0;
  endtask

  // Monitor: pops one expected item per interrupt.
  always @(negedge clk) begin
    if (rst_n && !done && irq) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected irq", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.chk_cap) check(32'(cap_data) == e.cap, {e.tag, " cap_data"}, int'(cap_data), e.cap);
        if (e.chk_ovf) check(ovf_flag == e.ovf, {e.tag, " ovf_flag"}, int'(ovf_flag), int'(e.ovf));
        if (e.at >= 0) check(cyc == e.at, {e.tag, " R11 capture timing"}, cyc, e.at);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cap_data === '0, "R1 cap_data", int'(cap_data), 0);
    check(ovf_flag === 1'b0, "R1 ovf_flag", int'(ovf_flag), 0);
    check(irq === 1'b0, "R1 irq", int'(irq), 0);
    check(chan_en === 1'b0, "R1 chan_en", int'(chan_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 first capture after start, R4 back-to-back periods
    do_start("R2 start");
    toggle_after(20, "R2");
    toggle_after(7, "R4");
    toggle_after(13, "R4");
    toggle_after(3, "R4");
    // R8 software capture while running
    sw_capture_after(10, "R8");
    toggle_after(9, "R8 after soft");

    // R3 falling only
    repeat (6) @(negedge clk);
    edge_sel = 2'd1;
    toggle_after(10, "R3 fall");
    toggle_after(10, "R3 fall");
    toggle_after(10, "R3 fall");
    repeat (6) @(negedge clk);
    edge_sel = 2'd0;
    toggle_after(10, "R3 rise");
    toggle_after(10, "R3 rise");
    toggle_after(10, "R3 rise");
    repeat (6) @(negedge clk);
    edge_sel = 2'd3;

    // R6 single wrap, R7 double wrap, then a short period clears the flag
    toggle_after(1500, "R6 one wrap");
    toggle_after(2600, "R7 two wraps");
    toggle_after(300, "R6 no wrap");

    // R9 stop: no captures, outputs kept
    repeat (6) @(negedge clk);
    do_stop("R9 stop");
    toggle_after(10, "R9");
    toggle_after(10, "R9");
    repeat (8) @(negedge clk);
    check(32'(cap_data) == 299, "R9 cap_data held", int'(cap_data), 299);
    check(ovf_flag === 1'b0, "R9 ovf_flag held", int'(ovf_flag), 0);
    do_start("R9 restart");
    repeat (8) @(negedge clk);
    check(32'(cap_data) == 299, "R9 start while off no capture", int'(cap_data), 299);
    toggle_after(50, "R2 restart");

    // R10 count clock every fourth cycle
    repeat (6) @(negedge clk);
    do_stop("R10 stop");
    clk_sel = 2'd2;
    ratio = 4;
    do_start("R10 start");
    toggle_after(16, "R10 first");
    toggle_after(20, "R10");
    toggle_after(28, "R10");
    toggle_after(8, "R10");

    repeat (30) @(negedge clk);
    check(sb.size() == 0, "R5 all captures reported", sb.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule